// File: doc/BRIEF.md
# ADC Sequence Status Register

This block holds the status word of an analog-to-digital conversion sequencer. It has three sticky event flags and a conversion slot counter. The flags are sequence complete, external trigger overrun and FIFO overrun. The conversion engine reports its events as one-cycle pulses: a conversion finished, a sequence finished, and a FIFO-mode result was overwritten before anyone read it. The trigger logic reports active trigger edges, and tells the block whether the trigger works on edges or on levels. Software reaches the word through a simple register bus and can read it at any time.

Each flag has its own mix of clear sources:
- a write of 1 to the flag's own bit;
- a write to the sequence-start control register;
- a write to one of the other control registers, which aborts the running sequence;
- for the sequence-complete flag only, a read of a result register while auto-clear is enabled.

Writing 0 to a flag does nothing. The counter cannot be written from the bus.

There is no streaming data path. Every strobe is taken in the cycle it is asserted, with no valid/ready handshake and no back-pressure. The read value is combinational from the state registers. An event or clear seen at a clock edge shows in `stat_rdata` right after that edge.

Top module: `adc_seq_status`

## Requirements
- R1: After reset `stat_rdata` is 0x00. Bit 6 always reads 0. Layout: bit 7 sequence complete, bit 5 trigger overrun, bit 4 FIFO overrun, bits 3:0 conversion counter.
- R2: A `seq_done` pulse sets the sequence-complete flag. It sets again on every later pulse, such as each pass of a continuous scan.
- R3: The sequence-complete flag clears on a register write with bit 7 = 1, or on any `start_wr`. A write with bit 7 = 0 leaves it unchanged.
- R4: A `res_rd` pulse clears the sequence-complete flag only while `auto_clr_en` is 1. With `auto_clr_en` = 0 it has no effect.
- R5: While `trig_level_mode` = 0, a `trig_edge` pulse with `seq_busy` = 1 sets the trigger overrun flag. With `seq_busy` = 0 it does not set the flag.
- R6: While `trig_level_mode` = 1, `trig_edge` never sets the trigger overrun flag.
- R7: The trigger overrun flag clears on a write with bit 5 = 1, on any bit of `ctl_wr`, or on `start_wr`.
- R8: `fifo_overwrite` sets the FIFO overrun flag. It clears on a write with bit 4 = 1 or on `start_wr`. It is not cleared by `ctl_wr`.
- R9: When a set event and a clear event for the same flag arrive in one cycle, the flag ends set.
- R10: Each `conv_done` pulse adds 1 to the counter, modulo 16, so 15 is followed by 0.
- R11: `start_wr` or any `ctl_wr` bit returns the counter to 0. This wins over a `conv_done` in the same cycle.
- R12: Register writes never change the counter bits, whatever data they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | Pulse: one conversion finished |
| seq_done | input | 1 | Pulse: a conversion sequence finished |
| seq_busy | input | 1 | A sequence is in progress |
| trig_edge | input | 1 | Pulse: active external trigger edge seen |
| trig_level_mode | input | 1 | 1 = level trigger, 0 = edge trigger |
| fifo_overwrite | input | 1 | Pulse: FIFO mode overwrote an unread result |
| reg_sel | input | 1 | Bus access targets this register |
| reg_we | input | 1 | Write strobe (with `reg_sel`) |
| reg_wdata | input | 8 | Write data; 1 in a flag bit clears that flag |
| ctl_wr | input | 5 | Write strobes of the other control registers (abort) |
| start_wr | input | 1 | Write strobe of the sequence-start register |
| res_rd | input | 1 | Pulse: a result register was read |
| auto_clr_en | input | 1 | Enables the sequence-complete clear on result read |
| stat_rdata | output | 8 | Status read value |

## Verification
Two things can land on the same edge:
- a flag's set event and one of its clear sources;
- a counter step and a restart.

The bench drives each pair together in one cycle:
- `seq_done` with `start_wr`;
- `trig_edge` during a busy sequence with an abort write;
- `fifo_overwrite` with a write-1-clear;
- `conv_done` with `start_wr`.

It then reads the word after that edge. The flags must be set and the counter must be 0. For contrast, the clear source alone must drop the flag.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int CNT_W    = 4;
  localparam int NUM_CTL  = 5;
  localparam int NUM_FLAG = 3;

  // bit positions software decodes
  localparam int BIT_SCF   = 7;
  localparam int BIT_RSVD  = 6;
  localparam int BIT_TOVR  = 5;
  localparam int BIT_FOVR  = 4;

  // flag index inside the flag array
  typedef enum logic [1:0] {
    FL_SEQ  = 2'd0,
    FL_TRIG = 2'd1,
    FL_FIFO = 2'd2
  } flag_idx_e;

  localparam logic [STAT_W-1:0] FLAG_MASK =
    STAT_W'((1 << BIT_SCF) | (1 << BIT_TOVR) | (1 << BIT_FOVR));
endpackage

// File: rtl/adc_sticky_flag.sv
module adc_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/adc_slot_counter.sv
module adc_slot_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_o <= '0;
    else if (restart_i) cnt_o <= '0;
    else if (step_i)    cnt_o <= cnt_o + ONE;
  end

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_o == '0));
  assert_step_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !restart_i) |=> (cnt_o == $past(cnt_o) + ONE));
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adc_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_done,
  input  logic               seq_done,
  input  logic               seq_busy,
  input  logic               trig_edge,
  input  logic               trig_level_mode,
  input  logic               fifo_overwrite,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [STAT_W-1:0]  reg_wdata,
  input  logic [NUM_CTL-1:0] ctl_wr,
  input  logic               start_wr,
  input  logic               res_rd,
  input  logic               auto_clr_en,
  output logic [STAT_W-1:0]  stat_rdata
);
  logic              bus_wr;
  logic              abort;
  logic [STAT_W-1:0] w1c;
  logic [NUM_FLAG-1:0] fl_set, fl_clr, fl_q;
  logic [CNT_W-1:0]  cnt;

  assign bus_wr = reg_sel & reg_we;
  assign abort  = |ctl_wr;
  assign w1c    = bus_wr ? (reg_wdata & FLAG_MASK) : '0;

  // set and clear sources per flag
  always_comb begin
    fl_set[FL_SEQ]  = seq_done;
    fl_clr[FL_SEQ]  = w1c[BIT_SCF] | start_wr | (res_rd & auto_clr_en);
    fl_set[FL_TRIG] = trig_edge & ~trig_level_mode & seq_busy;
    fl_clr[FL_TRIG] = w1c[BIT_TOVR] | abort | start_wr;
    fl_set[FL_FIFO] = fifo_overwrite;
    fl_clr[FL_FIFO] = w1c[BIT_FOVR] | start_wr;
  end

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    adc_sticky_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(fl_set[g]),
      .clr_i(fl_clr[g]),
      .q_o  (fl_q[g])
    );
  end

  adc_slot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(start_wr | abort),
    .step_i   (conv_done),
    .cnt_o    (cnt)
  );

  always_comb begin
    stat_rdata            = '0;
    stat_rdata[BIT_SCF]   = fl_q[FL_SEQ];
    stat_rdata[BIT_TOVR]  = fl_q[FL_TRIG];
    stat_rdata[BIT_FOVR]  = fl_q[FL_FIFO];
    stat_rdata[CNT_W-1:0] = cnt;
  end

  assert_trig_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[BIT_TOVR]) |-> $past(trig_edge && seq_busy && !trig_level_mode));
  assert_level_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_level_mode && !stat_rdata[BIT_TOVR]) |=> !stat_rdata[BIT_TOVR]);
  assert_rdclr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && !auto_clr_en && stat_rdata[BIT_SCF] && !start_wr &&
     !w1c[BIT_SCF]) |=> stat_rdata[BIT_SCF]);
  assert_fifo_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && stat_rdata[BIT_FOVR] && !start_wr && !w1c[BIT_FOVR])
      |=> stat_rdata[BIT_FOVR]);
  assert_bus_no_cnt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ((reg_wdata & ~FLAG_MASK) != '0) && !start_wr && !abort && !conv_done)
      |=> $stable(stat_rdata[CNT_W-1:0]));
  assert_rsvd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata[BIT_RSVD]);
endmodule

// File: tb/adc_seq_status_bench.sv
module adc_seq_status_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_done = 0, seq_done = 0, seq_busy = 0, trig_edge = 0;
  logic trig_level_mode = 0, fifo_overwrite = 0;
  logic reg_sel = 0, reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [4:0] ctl_wr = 0;
  logic start_wr = 0, res_rd = 0, auto_clr_en = 0;
  logic [7:0] stat_rdata;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_seq_status u_adc_seq_status (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .seq_done(seq_done),
    .seq_busy(seq_busy), .trig_edge(trig_edge), .trig_level_mode(trig_level_mode),
    .fifo_overwrite(fifo_overwrite), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .ctl_wr(ctl_wr), .start_wr(start_wr),
    .res_rd(res_rd), .auto_clr_en(auto_clr_en), .stat_rdata(stat_rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one clock with the current pulses, then drop all pulses (inputs move at posedge+1)
  task automatic tick();
    @(posedge clk); #1;
    conv_done = 0; seq_done = 0; trig_edge = 0; fifo_overwrite = 0;
    reg_sel = 0; reg_we = 0; reg_wdata = 0; ctl_wr = 0; start_wr = 0; res_rd = 0;
  endtask

  task automatic bus_write(input logic [7:0] d);
    reg_sel = 1; reg_we = 1; reg_wdata = d; tick();
  endtask

  task automatic t_reset();
    check("R1 reset value", stat_rdata, 8'h00);
  endtask

  task automatic t_seq_flag();
    seq_done = 1; tick(); check("R2 seq done sets", stat_rdata, 8'h80);
    bus_write(8'h00); check("R3 write 0 no effect", stat_rdata, 8'h80);
    bus_write(8'h80); check("R3 w1c clears", stat_rdata, 8'h00);
    seq_done = 1; tick(); seq_done = 1; tick();
    check("R2 sets on each scan pass", stat_rdata, 8'h80);
    start_wr = 1; tick(); check("R3 start clears", stat_rdata, 8'h00);
  endtask

  task automatic t_result_read();
    seq_done = 1; tick();
    auto_clr_en = 0; res_rd = 1; tick();
    check("R4 read ignored when disabled", stat_rdata, 8'h80);
    auto_clr_en = 1; res_rd = 1; tick();
    check("R4 read clears when enabled", stat_rdata, 8'h00);
    auto_clr_en = 0;
  endtask

  task automatic t_trig();
    trig_level_mode = 0; seq_busy = 0; trig_edge = 1; tick();
    check("R5 idle edge no overrun", stat_rdata, 8'h00);
    seq_busy = 1; trig_edge = 1; tick();
    check("R5 busy edge sets overrun", stat_rdata, 8'h20);
    bus_write(8'h20); check("R7 w1c clears overrun", stat_rdata, 8'h00);
    trig_edge = 1; tick(); ctl_wr = 5'b01000; tick();
    check("R7 ctl write clears overrun", stat_rdata, 8'h00);
    trig_edge = 1; tick(); start_wr = 1; tick();
    check("R7 start clears overrun", stat_rdata, 8'h00);
    trig_level_mode = 1; trig_edge = 1; tick(); trig_edge = 1; tick();
    check("R6 level mode no overrun", stat_rdata, 8'h00);
    trig_level_mode = 0; seq_busy = 0;
  endtask

  task automatic t_fifo();
    fifo_overwrite = 1; tick(); check("R8 overwrite sets", stat_rdata, 8'h10);
    ctl_wr = 5'b00001; tick(); check("R8 abort keeps fifo flag", stat_rdata, 8'h10);
    bus_write(8'h10); check("R8 w1c clears", stat_rdata, 8'h00);
    fifo_overwrite = 1; tick(); start_wr = 1; tick();
    check("R8 start clears", stat_rdata, 8'h00);
  endtask

  task automatic t_collide();
    seq_done = 1; start_wr = 1; tick();
    check("R9 seq set beats start", stat_rdata, 8'h80);
    seq_busy = 1; trig_edge = 1; ctl_wr = 5'b10000; tick();
    check("R9 overrun set beats abort", stat_rdata, 8'hA0);
    fifo_overwrite = 1; reg_sel = 1; reg_we = 1; reg_wdata = 8'h10; tick();
    check("R9 fifo set beats w1c", stat_rdata, 8'hB0);
    bus_write(8'hB0); seq_busy = 0;
    check("R9 all cleared afterwards", stat_rdata, 8'h00);
  endtask

  task automatic t_counter();
    for (int i = 0; i < 15; i++) begin conv_done = 1; tick(); end
    check("R10 counts to 15", stat_rdata, 8'h0F);
    conv_done = 1; tick(); check("R10 wraps to 0", stat_rdata, 8'h00);
    conv_done = 1; tick(); conv_done = 1; tick(); conv_done = 1; tick();
    bus_write(8'h4F); check("R12 write keeps count", stat_rdata, 8'h03);
    bus_write(8'h40); check("R12 write zeros keeps count", stat_rdata, 8'h03);
    conv_done = 1; start_wr = 1; tick();
    check("R11 start beats step", stat_rdata, 8'h00);
    conv_done = 1; tick(); conv_done = 1; tick(); ctl_wr = 5'b00100; tick();
    check("R11 abort resets count", stat_rdata, 8'h00);
    conv_done = 1; tick(); check("R10 step after restart", stat_rdata, 8'h01);
  endtask

  initial begin
    #1;
    check("R1 value in reset", stat_rdata, 8'h00);
    repeat (3) @(posedge clk); #1; rst_n = 1;
    t_reset();
    t_seq_flag();
    t_result_read();
    t_trig();
    t_fifo();
    t_collide();
    t_counter();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule